// File: doc/BRIEF.md
# Branch Condition and Target Evaluator

This unit sits beside the instruction sequencer of an 8-bit microcontroller core and settles every conditional branch. When the sequencer presents a branch opcode with a start strobe, the unit checks the opcode against the current condition-code flags, the level of the external interrupt-request pin, and, for bit-test branches, one bit of a memory operand byte. It then returns whether the branch is taken, the next program counter, the instruction's cycle count, and whether the opcode is a branch it knows.

The result appears in the registers on the clock edge that samples the start strobe, together with a one-cycle done pulse. Between strobes the outputs hold. The interrupt-request pin is asynchronous, so it passes through a two-flop synchronizer before any condition uses it. The unit only reads the flags. It has no path that writes them.

Top module: `brc_eval`

## Requirements
- R1: `done` is high for exactly the one cycle after each cycle in which `start` is high. `taken`, `valid`, `next_pc` and `cycles` change only on an edge where `start` is sampled high, and they hold otherwise.
- R2: A relative branch (opcodes 0x20–0x2F except 0x27, and 0x90–0x93) gives `next_pc` = `pc_in` + 2 + the sign-extended `disp` when taken, and `pc_in` + 2 when not taken. The result is modulo 2^16, and `cycles` = 3.
- R3: The signed-compare branches are taken under these conditions: 0x90 when N xor V = 0, 0x91 when N xor V = 1, 0x92 when Z or (N xor V) = 0, and 0x93 when Z or (N xor V) = 1.
- R4: The unsigned-compare branches are taken under these conditions: 0x22 when C or Z = 0, 0x23 when C or Z = 1, 0x24 when C = 0, and 0x25 when C = 1.
- R5: The single-flag branches are taken under these conditions: 0x26 when Z = 0, 0x28 when H = 0, 0x29 when H = 1, 0x2A when N = 0, 0x2B when N = 1, 0x2C when I = 0, and 0x2D when I = 1.
- R6: 0x2E is taken when the synchronized pin is low, and 0x2F when it is high. The value used is the `irq_pin` level sampled two rising edges before the edge that captures `start`.
- R7: 0x20 is always taken. 0x21 is never taken and gives `pc_in` + 2.
- R8: Opcodes 0x00–0x0F are bit-test branches. They test bit `opcode[3:1]` of `mem_byte`. When `opcode[0]` = 0 the branch is taken if that bit is 1; when `opcode[0]` = 1 it is taken if that bit is 0. `next_pc` is `pc_in` + 3 + the sign-extended `disp` when taken and `pc_in` + 3 when not, and `cycles` = 5.
- R9: Any other opcode gives `valid` = 0, `taken` = 0, `next_pc` = `pc_in` + 2 and `cycles` = 0. A listed opcode gives `valid` = 1.
- R10: After reset, `done`, `taken`, `valid`, `next_pc` and `cycles` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Evaluate the presented instruction |
| opcode | input | 8 | Branch opcode |
| flag_v | input | 1 | Overflow flag |
| flag_h | input | 1 | Half-carry flag |
| flag_i | input | 1 | Interrupt mask flag |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| irq_pin | input | 1 | Asynchronous interrupt-request pin level |
| mem_byte | input | 8 | Operand byte for bit-test branches |
| pc_in | input | 16 | Address of the branch instruction |
| disp | input | 8 | Signed displacement |
| done | output | 1 | Result registers were updated last edge |
| taken | output | 1 | Branch taken |
| next_pc | output | 16 | Next program counter |
| cycles | output | 3 | Instruction cycle count |
| valid | output | 1 | Opcode is a known branch |

## Verification
Every one of the 256 opcodes is tried under several flag words. These include all-clear, all-set and the two alternating patterns. They separate each condition from its complement and keep the signed tests apart from the unsigned ones. The four signed-compare opcodes are also swept over all 64 flag combinations, which shows that N xor V and Z are combined correctly and that no other flag leaks in. Bit-test branches are tried with one-hot and alternating operand bytes in both polarities, so a wrong bit index or an inverted sense is caught. Displacements of 0x7F and 0x80, with program counters near 0x0000 and 0xFFFF, check sign extension and wraparound. A pin toggled at the same moment as `start` checks the synchronizer latency.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [1:0] {
    KIND_REL = 2'd0,
    KIND_BIT = 2'd1,
    KIND_BAD = 2'd2
  } brc_kind_e;

  typedef struct packed {
    logic v;
    logic h;
    logic i;
    logic n;
    logic z;
    logic c;
  } brc_flags_t;

  // Condition truth for an opcode. The kind is returned separately.
  function automatic logic brc_condition(input logic [7:0] op,
                                         input brc_flags_t f,
                                         input logic pin,
                                         input logic [7:0] mem);
    logic sgn;
    logic bitv;
    sgn  = f.n ^ f.v;
    bitv = mem[op[3:1]];
    case (op) inside
      [8'h00:8'h0F]: brc_condition = op[0] ? ~bitv : bitv;
      8'h20: brc_condition = 1'b1;
      8'h21: brc_condition = 1'b0;
      8'h22: brc_condition = ~(f.c | f.z);
      8'h23: brc_condition = f.c | f.z;
      8'h24: brc_condition = ~f.c;
      8'h25: brc_condition = f.c;
      8'h26: brc_condition = ~f.z;
      8'h28: brc_condition = ~f.h;
      8'h29: brc_condition = f.h;
      8'h2A: brc_condition = ~f.n;
      8'h2B: brc_condition = f.n;
      8'h2C: brc_condition = ~f.i;
      8'h2D: brc_condition = f.i;
      8'h2E: brc_condition = ~pin;
      8'h2F: brc_condition = pin;
      8'h90: brc_condition = ~sgn;
      8'h91: brc_condition = sgn;
      8'h92: brc_condition = ~(f.z | sgn);
      8'h93: brc_condition = f.z | sgn;
      default: brc_condition = 1'b0;
    endcase
  endfunction

  function automatic brc_kind_e brc_classify(input logic [7:0] op);
    case (op) inside
      [8'h00:8'h0F]: brc_classify = KIND_BIT;
      8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26,
      8'h28, 8'h29, 8'h2A, 8'h2B, 8'h2C, 8'h2D, 8'h2E, 8'h2F,
      8'h90, 8'h91, 8'h92, 8'h93: brc_classify = KIND_REL;
      default: brc_classify = KIND_BAD;
    endcase
  endfunction

endpackage

// File: rtl/brc_sync.sv
module brc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
(
  input  logic [7:0]  opcode,
  input  brc_flags_t  flags,
  input  logic        pin_sync,
  input  logic [7:0]  mem_byte,
  output brc_kind_e   kind,
  output logic        cond_true
);
  always_comb begin
    kind      = brc_classify(opcode);
    cond_true = (kind != KIND_BAD) && brc_condition(opcode, flags, pin_sync, mem_byte);
  end
endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DISP_W-1:0] disp,
  input  logic              long_form,
  input  logic              take,
  output logic [PC_W-1:0]   next_pc
);
  localparam int EXT_W = PC_W - DISP_W;

  function automatic logic [PC_W-1:0] sext(input logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [PC_W-1:0] advance(input logic [PC_W-1:0] pc,
                                              input logic long_f);
    return pc + (long_f ? PC_W'(3) : PC_W'(2));
  endfunction

  logic [PC_W-1:0] fall_thru;

  always_comb begin
    fall_thru = advance(pc_in, long_form);
    next_pc   = take ? fall_thru + sext(disp) : fall_thru;
  end
endmodule

// File: rtl/brc_eval.sv
module brc_eval
  import brc_pkg::*;
#(
  parameter int PC_W        = 16,
  parameter int DISP_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CYC_W       = 3,
  parameter int REL_CYCLES  = 3,
  parameter int BIT_CYCLES  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic              flag_v,
  input  logic              flag_h,
  input  logic              flag_i,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              irq_pin,
  input  logic [7:0]        mem_byte,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DISP_W-1:0] disp,
  output logic              done,
  output logic              taken,
  output logic [PC_W-1:0]   next_pc,
  output logic [CYC_W-1:0]  cycles,
  output logic              valid
);
  localparam logic [CYC_W-1:0] REL_CNT = CYC_W'(REL_CYCLES);
  localparam logic [CYC_W-1:0] BIT_CNT = CYC_W'(BIT_CYCLES);

  brc_flags_t      flags;
  logic            pin_s;
  brc_kind_e       kind;
  logic            cond_true;
  logic            bit_form;
  logic            bad_op;
  logic [PC_W-1:0] target;

  assign flags = '{v: flag_v, h: flag_h, i: flag_i, n: flag_n, z: flag_z, c: flag_c};

  brc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(irq_pin), .q_sync(pin_s)
  );

  brc_decode u_dec (
    .opcode(opcode), .flags(flags), .pin_sync(pin_s), .mem_byte(mem_byte),
    .kind(kind), .cond_true(cond_true)
  );

  assign bit_form = (kind == KIND_BIT);
  assign bad_op   = (kind == KIND_BAD);

  brc_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
    .pc_in(pc_in), .disp(disp), .long_form(bit_form), .take(cond_true),
    .next_pc(target)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      taken   <= 1'b0;
      next_pc <= '0;
      cycles  <= '0;
      valid   <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        taken   <= cond_true;
        next_pc <= target;
        valid   <= ~bad_op;
        cycles  <= bad_op ? '0 : (bit_form ? BIT_CNT : REL_CNT);
      end
    end
  end
endmodule

// File: rtl/brc_eval_chk.sv
module brc_eval_chk #(
  parameter int PC_W       = 16,
  parameter int CYC_W      = 3,
  parameter int REL_CYCLES = 3,
  parameter int BIT_CYCLES = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [7:0]       opcode,
  input logic [PC_W-1:0]  pc_in,
  input logic             done,
  input logic             taken,
  input logic [PC_W-1:0]  next_pc,
  input logic [CYC_W-1:0] cycles,
  input logic             valid
);
  a_r1_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(next_pc) && $stable(taken) && $stable(valid) && $stable(cycles)));

  a_r9_illegal_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !valid) |-> (!taken && cycles == '0 &&
                          next_pc == PC_W'($past(pc_in) + PC_W'(2))));

  a_r2_rel_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (done && valid && $past(opcode[7:4]) != 4'h0) |-> cycles == CYC_W'(REL_CYCLES));

  a_r8_bit_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (done && valid && $past(opcode[7:4]) == 4'h0) |-> cycles == CYC_W'(BIT_CYCLES));

  a_r7_always: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(opcode) == 8'h20) |-> (taken && valid));

  a_r7_never: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(opcode) == 8'h21) |-> (!taken && next_pc == PC_W'($past(pc_in) + PC_W'(2))));
endmodule

bind brc_eval brc_eval_chk #(
  .PC_W(PC_W), .CYC_W(CYC_W), .REL_CYCLES(REL_CYCLES), .BIT_CYCLES(BIT_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pc_in(pc_in),
  .done(done), .taken(taken), .next_pc(next_pc), .cycles(cycles), .valid(valid)
);

// File: tb/tb_brc_eval.sv
`timescale 1ns/1ps
module tb_brc_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [5:0]  fl = 6'h00;   // {v,h,i,n,z,c}
  logic        irq_pin = 1'b0;
  logic [7:0]  mem_byte = 8'h00;
  logic [15:0] pc_in = 16'h0000;
  logic [7:0]  disp = 8'h00;
  logic        done, taken, valid;
  logic [15:0] next_pc;
  logic [2:0]  cycles;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  brc_eval dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .flag_v(fl[5]), .flag_h(fl[4]), .flag_i(fl[3]), .flag_n(fl[2]),
    .flag_z(fl[1]), .flag_c(fl[0]), .irq_pin(irq_pin), .mem_byte(mem_byte),
    .pc_in(pc_in), .disp(disp), .done(done), .taken(taken),
    .next_pc(next_pc), .cycles(cycles), .valid(valid)
  );

  // Reference model
  bit        m_s1, m_s2;
  bit        e_done, e_taken, e_valid;
  int        e_pc, e_cyc;
  string     e_tag = "R10";

  function automatic string tag_of(int op);
    if (op < 16) return "R8";
    if (op == 32 || op == 33) return "R2/R7";
    if (op >= 34 && op <= 37) return "R2/R4";
    if (op == 38 || (op >= 40 && op <= 45)) return "R2/R5";
    if (op == 46 || op == 47) return "R2/R6";
    if (op >= 144 && op <= 147) return "R2/R3";
    return "R9";
  endfunction

  task automatic model(input int op, input bit [5:0] f, input bit pin,
                       input int mem, input int pc, input int d,
                       output bit ok, output bit tk, output int npc, output int cyc);
    bit v, h, i, n, z, c;
    int off, step;
    {v, h, i, n, z, c} = f;
    ok = 1; tk = 0; step = 2; cyc = 3;
    if (op < 16) begin
      step = 3; cyc = 5;
      tk = (((mem >> (op / 2)) & 1) == 1) == (op % 2 == 0);
    end else begin
      case (op)
        32: tk = 1;
        33: tk = 0;
        34: tk = !(c || z);
        35: tk = c || z;
        36: tk = !c;
        37: tk = c;
        38: tk = !z;
        40: tk = !h;
        41: tk = h;
        42: tk = !n;
        43: tk = n;
        44: tk = !i;
        45: tk = i;
        46: tk = !pin;
        47: tk = pin;
        144: tk = (n == v);
        145: tk = (n != v);
        146: tk = !z && (n == v);
        147: tk = z || (n != v);
        default: begin ok = 0; cyc = 0; end
      endcase
    end
    off = (d >= 128) ? d - 256 : d;
    npc = (pc + step + (tk ? off : 0)) & 16'hFFFF;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0;
      e_done <= 0; e_taken <= 0; e_valid <= 0; e_pc <= 0; e_cyc <= 0;
    end else begin
      bit ok, tk; int npc, cyc;
      m_s1 <= irq_pin;
      m_s2 <= m_s1;
      e_done <= start;
      if (start) begin
        model(opcode, fl, m_s2, mem_byte, pc_in, disp, ok, tk, npc, cyc);
        e_taken <= tk; e_valid <= ok; e_pc <= npc; e_cyc <= cyc;
        e_tag <= tag_of(opcode);
      end else begin
        e_tag <= "R1";
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (done !== e_done || taken !== e_taken || valid !== e_valid ||
          int'(next_pc) != e_pc || int'(cycles) != e_cyc) begin
        failures++;
        $display("FAIL %s: done=%0b taken=%0b valid=%0b pc=%h cyc=%0d expected done=%0b taken=%0b valid=%0b pc=%h cyc=%0d",
                 e_tag, done, taken, valid, next_pc, cycles,
                 e_done, e_taken, e_valid, e_pc[15:0], e_cyc);
      end
    end
  end

  task automatic issue(input int op, input bit [5:0] f, input int mem,
                       input int pc, input int d);
    @(negedge clk);
    opcode = op[7:0]; fl = f; mem_byte = mem[7:0]; pc_in = pc[15:0]; disp = d[7:0];
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    bit [5:0] pats [6] = '{6'h00, 6'h3F, 6'h15, 6'h2A, 6'h05, 6'h22};
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (done !== 0 || taken !== 0 || valid !== 0 || next_pc !== 16'h0 || cycles !== 3'd0) begin
      failures++;
      $display("FAIL R10: done=%0b taken=%0b valid=%0b pc=%h cyc=%0d expected all zero",
               done, taken, valid, next_pc, cycles);
    end
    rst_n = 1;
    @(negedge clk);

    // All opcodes under several flag words (R2..R9)
    for (int op = 0; op < 256; op++)
      for (int p = 0; p < 6; p++)
        issue(op, pats[p], {p[1:0], 6'h15} ^ op, 16'h1000 + op * 7, 8'h10 + p * 40);

    // R3: exhaustive flags for signed compares
    for (int op = 144; op < 148; op++)
      for (int f = 0; f < 64; f++)
        issue(op, f[5:0], 0, 16'h4000, 8'hF0);

    // R8: bit-test with one-hot and alternating operands
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 8; k++) issue(op, 6'h00, 1 << k, 16'h2000, 8'h05);
      issue(op, 6'h00, 8'h55, 16'h2000, 8'hFB);
      issue(op, 6'h00, 8'hAA, 16'h2000, 8'hFB);
    end

    // R2: sign extension and wraparound
    issue(8'h20, 6'h00, 0, 16'h0010, 8'h80);
    issue(8'h20, 6'h00, 0, 16'hFFFE, 8'h7F);
    issue(8'h21, 6'h00, 0, 16'hFFFF, 8'h7F);
    issue(8'h01, 6'h00, 0, 16'hFFFE, 8'h80);
    issue(8'h00, 6'h00, 8'h01, 16'hFFF0, 8'h7F);

    // R6: pin latency through the synchronizer
    irq_pin = 0;
    repeat (4) @(negedge clk);
    opcode = 8'h2F; pc_in = 16'h3000; disp = 8'h20; irq_pin = 1; start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    issue(8'h2F, 6'h00, 0, 16'h3000, 8'h20);
    issue(8'h2E, 6'h00, 0, 16'h3000, 8'h20);
    @(negedge clk);
    irq_pin = 0; opcode = 8'h2E; start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);

    // R1: back-to-back strobes then idle hold
    issue(8'h26, 6'h00, 0, 16'h5000, 8'h02);
    issue(8'h26, 6'h02, 0, 16'h5100, 8'h02);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule